// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block sequences the high-side and low-side gate drives of one power half-bridge. It accepts PWM commands in one of two forms. In six-input form, a separate command is given for each gate. In three-input form, one command picks the high or low output, and the other gate is its complement. A transition is never driven blindly. The incoming gate waits until the outgoing gate is released and its gate-source comparator reports it below threshold. A programmable digital dead time then runs before the incoming gate is switched on.

Every gate transition, on or off, opens a drive window on its own side, timed by a counter owned by that side. While the window is open, a strong pulldown is held on the opposite gate so that coupled charge cannot turn it on. When the window closes, the switching gate's comparator is checked. A gate that has not reached its expected level raises a gate-drive fault. The fault stays set until a clear pulse arrives, and both gates are held off while it is set. Dead time and window length are cycle counts on configuration inputs. They are captured only while both sides are at rest.

Top module: `hb_gate_seq`

## Requirements
- R1: In six-input mode (`mode_3x`=0), `gate_hi` follows `cmd_hi` and `gate_lo` follows `cmd_lo`, each through the dead-time and window sequencing below.
- R2: In six-input mode, when `cmd_hi` and `cmd_lo` are both 1, both gates are released and stay off.
- R3: In three-input mode (`mode_3x`=1), `cmd_hi`=1 selects the high gate and `cmd_hi`=0 selects the low gate. `cmd_lo` has no effect on either gate.
- R4: A gate is switched on only after the opposite gate is undriven, its drive window has closed, and its monitor (`vgs_*_mon`, 1 = above threshold) reads 0.
- R5: Once the R4 condition is first seen at a clock edge, the incoming gate turns on exactly `dead_q` clock edges later. `dead_q` is the captured dead-time count, and 0 means the gate turns on at the same edge.
- R6: `gate_hi` and `gate_lo` are never 1 together.
- R7: Each turn-on and each turn-off opens a window of `win_q` cycles. During that window the strong pulldown of the opposite gate (`pull_lo` for a high-side window, `pull_hi` for a low-side window) is 1. A captured window of 0 is treated as 1.
- R8: At the last cycle of a turn-on window, a monitor reading 0 raises `fault`. At the last cycle of a turn-off window, a monitor reading 1 raises `fault`.
- R9: `fault` stays 1 until `fault_clr` is 1 at a clock edge with no new fault. While `fault` is 1, both gates are off and commands are ignored. After the clear, the gates follow the commands again.
- R10: `cfg_dead` and `cfg_win` are captured only at edges where both sides are fully off or steadily on. A change made during a transition applies from the next transition.
- R11: Each side has its own window timer, started only by its own transition. The two pulldowns are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_3x | input | 1 | 1 = three-input command mode, 0 = six-input mode |
| cmd_hi | input | 1 | High-side command; the half-bridge command in three-input mode |
| cmd_lo | input | 1 | Low-side command; unused in three-input mode |
| vgs_hi_mon | input | 1 | High-side gate-source comparator, 1 = above threshold |
| vgs_lo_mon | input | 1 | Low-side gate-source comparator, 1 = above threshold |
| cfg_dead | input | DEAD_W | Digital dead time in cycles |
| cfg_win | input | WIN_W | Drive-window length in cycles |
| fault_clr | input | 1 | Clears the sticky fault |
| gate_hi | output | 1 | High-side gate drive on |
| gate_lo | output | 1 | Low-side gate drive on |
| pull_hi | output | 1 | Strong pulldown on the high-side gate |
| pull_lo | output | 1 | Strong pulldown on the low-side gate |
| fault | output | 1 | Sticky gate-drive fault |

## Verification
The hardest situation to reach from the ports is a monitor that disagrees with its gate at the exact closing cycle of a window. This covers both a gate that never rises after it is driven and one that stays high after it is released. The bench models each comparator as a gate delayed by a fixed lag, and it can force either comparator to a stuck value. Forcing the high-side monitor to 1 before a high-to-low handover gives a turn-off fault. Forcing it to 0 before a low-to-high handover gives a turn-on fault. A configuration change placed two cycles into a handover shows that dead time is captured only at rest.

// File: rtl/hb_gate_pkg.sv
// Shared types for the half-bridge gate sequencer.
// Assumes: two sides, index 0 is the high side, index 1 the low side.
package hb_gate_pkg;

    localparam int SIDE_HI = 0;
    localparam int SIDE_LO = 1;
    localparam int N_SIDES = 2;

    // Per-side sequencing state
    typedef enum logic [2:0] {
        SQ_OFF    = 3'd0,  // released, window closed
        SQ_WAIT   = 3'd1,  // wants on, waiting for opposite gate to be off
        SQ_DEAD   = 3'd2,  // digital dead time running
        SQ_ONWIN  = 3'd3,  // driven, turn-on window open
        SQ_ON     = 3'd4,  // driven, steady
        SQ_OFFWIN = 3'd5   // released, turn-off window open
    } side_st_e;

endpackage

// File: rtl/hb_cmd_decode.sv
// Command decoder: turns the PWM command inputs into a wanted state per
// side. Assumes the two wants are mutually exclusive in every mode.
module hb_cmd_decode
    import hb_gate_pkg::*;
(
    input  logic               mode_3x,
    input  logic               cmd_hi,
    input  logic               cmd_lo,
    output logic [N_SIDES-1:0] want
);

    // Map commands onto per-side wants; equal six-input commands release both
    always_comb begin
        if (mode_3x) begin
            want[SIDE_HI] = cmd_hi;
            want[SIDE_LO] = ~cmd_hi;
        end else begin
            want[SIDE_HI] = cmd_hi & ~cmd_lo;
            want[SIDE_LO] = cmd_lo & ~cmd_hi;
        end
    end

endmodule

// File: rtl/hb_cfg_hold.sv
// Configuration holder: captures dead time and window length while the
// bridge is at rest, so a transition never sees its timing change midway.
// Assumes: a window length of zero is meaningless and is raised to one.
module hb_cfg_hold #(
    parameter int DEAD_W = 4,
    parameter int WIN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DEAD_W-1:0] cfg_dead,
    input  logic [WIN_W-1:0]  cfg_win,
    output logic [DEAD_W-1:0] dead_q,
    output logic [WIN_W-1:0]  win_q
);

    logic [WIN_W-1:0] win_clamped;

    // Raise a zero window to one cycle
    always_comb begin
        win_clamped = (cfg_win == '0) ? WIN_W'(1) : cfg_win;
    end

    // Capture both counts only when the sides are at rest
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dead_q <= '0;
            win_q  <= WIN_W'(1);
        end else if (capture) begin
            dead_q <= cfg_dead;
            win_q  <= win_clamped;
        end
    end

endmodule

// File: rtl/hb_side_seq.sv
// One side of the half-bridge: waits for the opposite gate to be fully off,
// runs the digital dead time, then drives its gate with a drive window on
// both turn-on and turn-off. Flags a bad monitor level at window end.
// Assumes: kill_i forces the side off at once and has priority over all.
module hb_side_seq
    import hb_gate_pkg::*;
#(
    parameter int DEAD_W = 4,
    parameter int WIN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want_i,
    input  logic              opp_off_i,
    input  logic              opp_mon_i,
    input  logic              own_mon_i,
    input  logic              kill_i,
    input  logic [DEAD_W-1:0] dead_i,
    input  logic [WIN_W-1:0]  win_i,
    output logic              drive_o,
    output logic              in_win_o,
    output logic              off_o,
    output logic              steady_o,
    output logic              bad_o
);

    localparam int CNT_W = (DEAD_W > WIN_W) ? DEAD_W : WIN_W;

    side_st_e          st_q;
    side_st_e          st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;
    logic [CNT_W-1:0]  dead_load;
    logic [CNT_W-1:0]  win_load;
    logic              cnt_done;
    logic              path_clear;

    // Counter reload values and end-of-interval flag
    always_comb begin
        dead_load  = CNT_W'(dead_i) - CNT_W'(1);
        win_load   = CNT_W'(win_i) - CNT_W'(1);
        cnt_done   = (cnt_q == '0);
        path_clear = opp_off_i & ~opp_mon_i;
    end

    // Monitor check at the last cycle of a window
    always_comb begin
        bad_o = 1'b0;
        if (cnt_done) begin
            if (st_q == SQ_ONWIN && want_i && !own_mon_i) begin
                bad_o = 1'b1;
            end
            if (st_q == SQ_OFFWIN && own_mon_i) begin
                bad_o = 1'b1;
            end
        end
    end

    // Next state and counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (kill_i) begin
            st_d  = SQ_OFF;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                SQ_OFF: begin
                    if (want_i) st_d = SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (!want_i) begin
                        st_d = SQ_OFF;
                    end else if (path_clear) begin
                        if (dead_i == '0) begin
                            st_d  = SQ_ONWIN;
                            cnt_d = win_load;
                        end else begin
                            st_d  = SQ_DEAD;
                            cnt_d = dead_load;
                        end
                    end
                end
                SQ_DEAD: begin
                    if (!want_i) begin
                        st_d = SQ_OFF;
                    end else if (cnt_done) begin
                        st_d  = SQ_ONWIN;
                        cnt_d = win_load;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                SQ_ONWIN: begin
                    if (!want_i) begin
                        st_d  = SQ_OFFWIN;
                        cnt_d = win_load;
                    end else if (cnt_done) begin
                        st_d = SQ_ON;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                SQ_ON: begin
                    if (!want_i) begin
                        st_d  = SQ_OFFWIN;
                        cnt_d = win_load;
                    end
                end
                SQ_OFFWIN: begin
                    if (cnt_done) begin
                        st_d = SQ_OFF;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                default: begin
                    st_d  = SQ_OFF;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Status decode for the gate, the pulldown and the neighbour
    always_comb begin
        drive_o  = (st_q == SQ_ONWIN) || (st_q == SQ_ON);
        in_win_o = (st_q == SQ_ONWIN) || (st_q == SQ_OFFWIN);
        off_o    = (st_q == SQ_OFF);
        steady_o = (st_q == SQ_OFF) || (st_q == SQ_ON);
    end

endmodule

// File: rtl/hb_gate_seq.sv
// Half-bridge gate sequencer top: decodes commands, holds configuration,
// runs one sequencer per side and keeps the sticky fault.
// Assumes: monitors are already synchronous to clk.
module hb_gate_seq
    import hb_gate_pkg::*;
#(
    parameter int DEAD_W = 4,
    parameter int WIN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_3x,
    input  logic              cmd_hi,
    input  logic              cmd_lo,
    input  logic              vgs_hi_mon,
    input  logic              vgs_lo_mon,
    input  logic [DEAD_W-1:0] cfg_dead,
    input  logic [WIN_W-1:0]  cfg_win,
    input  logic              fault_clr,
    output logic              gate_hi,
    output logic              gate_lo,
    output logic              pull_hi,
    output logic              pull_lo,
    output logic              fault
);

    logic [N_SIDES-1:0] want;
    logic [N_SIDES-1:0] mon;
    logic [N_SIDES-1:0] drive;
    logic [N_SIDES-1:0] in_win;
    logic [N_SIDES-1:0] is_off;
    logic [N_SIDES-1:0] steady;
    logic [N_SIDES-1:0] bad;
    logic [DEAD_W-1:0]  dead_q;
    logic [WIN_W-1:0]   win_q;
    logic               fault_q;
    logic               kill;

    // Gather monitors per side index
    always_comb begin
        mon[SIDE_HI] = vgs_hi_mon;
        mon[SIDE_LO] = vgs_lo_mon;
        kill         = fault_q | (|bad);
    end

    hb_cmd_decode u_decode (
        .mode_3x (mode_3x),
        .cmd_hi  (cmd_hi),
        .cmd_lo  (cmd_lo),
        .want    (want)
    );

    hb_cfg_hold #(
        .DEAD_W (DEAD_W),
        .WIN_W  (WIN_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (&steady),
        .cfg_dead (cfg_dead),
        .cfg_win  (cfg_win),
        .dead_q   (dead_q),
        .win_q    (win_q)
    );

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        hb_side_seq #(
            .DEAD_W (DEAD_W),
            .WIN_W  (WIN_W)
        ) u_side (
            .clk       (clk),
            .rst_n     (rst_n),
            .want_i    (want[s]),
            .opp_off_i (is_off[N_SIDES-1-s]),
            .opp_mon_i (mon[N_SIDES-1-s]),
            .own_mon_i (mon[s]),
            .kill_i    (kill),
            .dead_i    (dead_q),
            .win_i     (win_q),
            .drive_o   (drive[s]),
            .in_win_o  (in_win[s]),
            .off_o     (is_off[s]),
            .steady_o  (steady[s]),
            .bad_o     (bad[s])
        );
    end

    // Sticky fault: set by any bad window end, cleared by a clear pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (|bad) begin
            fault_q <= 1'b1;
        end else if (fault_clr) begin
            fault_q <= 1'b0;
        end
    end

    // Drive outputs; each pulldown follows the opposite side's window
    always_comb begin
        gate_hi = drive[SIDE_HI];
        gate_lo = drive[SIDE_LO];
        pull_lo = in_win[SIDE_HI];
        pull_hi = in_win[SIDE_LO];
        fault   = fault_q;
    end

endmodule

// File: rtl/hb_gate_seq_chk.sv
// Property checker for the half-bridge sequencer, bound to every instance.
module hb_gate_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic gate_hi,
    input logic gate_lo,
    input logic pull_hi,
    input logic pull_lo,
    input logic fault,
    input logic fault_clr
);

    // R6
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    // R4
    hi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> $past(!gate_lo && !pull_hi));

    // R4
    lo_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> $past(!gate_hi && !pull_lo));

    // R7
    pull_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_lo |-> !gate_lo);

    // R7
    pull_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_hi |-> !gate_hi);

    // R8
    fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(pull_hi || pull_lo));

    // R9
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!gate_hi && !gate_lo));

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault);

    // R11
    win_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pull_hi && pull_lo));

endmodule

bind hb_gate_seq hb_gate_seq_chk u_hb_gate_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .pull_hi   (pull_hi),
    .pull_lo   (pull_lo),
    .fault     (fault),
    .fault_clr (fault_clr)
);

// File: tb/hb_gate_seq_bench.sv
module hb_gate_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEAD_W     = 4;
    localparam int WIN_W      = 5;
    localparam int LAG        = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_3x = 1'b0;
    logic              cmd_hi = 1'b0;
    logic              cmd_lo = 1'b0;
    logic              vgs_hi_mon;
    logic              vgs_lo_mon;
    logic [DEAD_W-1:0] cfg_dead = 4'd2;
    logic [WIN_W-1:0]  cfg_win = 5'd4;
    logic              fault_clr = 1'b0;
    logic              gate_hi, gate_lo, pull_hi, pull_lo, fault;

    int n_tests = 0;
    int n_fail  = 0;

    // gate plant: comparator = gate delayed by LAG, optionally stuck
    logic [7:0] sh_h = '0, sh_l = '0;
    logic stuck_h_en = 1'b0, stuck_h_val = 1'b0;
    assign vgs_hi_mon = stuck_h_en ? stuck_h_val : sh_h[LAG-1];
    assign vgs_lo_mon = sh_l[LAG-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        sh_h <= {sh_h[6:0], gate_hi};
        sh_l <= {sh_l[6:0], gate_lo};
    end

    hb_gate_seq #(.DEAD_W(DEAD_W), .WIN_W(WIN_W)) u_hb_gate_seq (
        .clk(clk), .rst_n(rst_n), .mode_3x(mode_3x), .cmd_hi(cmd_hi),
        .cmd_lo(cmd_lo), .vgs_hi_mon(vgs_hi_mon), .vgs_lo_mon(vgs_lo_mon),
        .cfg_dead(cfg_dead), .cfg_win(cfg_win), .fault_clr(fault_clr),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .pull_hi(pull_hi),
        .pull_lo(pull_lo), .fault(fault)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model (phases as integers) ----------------
    // 0 idle, 1 waiting, 2 dead time, 3 on window, 4 on, 5 off window
    int mp_h = 0, mp_l = 0, me_h = 0, me_l = 0, mdead = 0, mwin = 1;
    bit mflt = 0;

    task automatic side_step(input int ph, input int el, input bit want,
                             input int oph, input bit omon, input bit kill,
                             output int nph, output int nel);
        nph = ph; nel = el;
        if (kill) begin
            nph = 0; nel = 0;
        end else begin
            case (ph)
                0: if (want) nph = 1;
                1: if (!want) nph = 0;
                   else if (oph == 0 && !omon) begin nph = (mdead == 0) ? 3 : 2; nel = 1; end
                2: if (!want) nph = 0;
                   else if (el >= mdead) begin nph = 3; nel = 1; end
                   else nel = el + 1;
                3: if (!want) begin nph = 5; nel = 1; end
                   else if (el >= mwin) nph = 4;
                   else nel = el + 1;
                4: if (!want) begin nph = 5; nel = 1; end
                5: if (el >= mwin) nph = 0; else nel = el + 1;
                default: nph = 0;
            endcase
        end
    endtask

    always @(posedge clk) begin : model
        bit wh, wl, bh, bl, kill;
        int nph, neh, npl, nel;
        if (!rst_n) begin
            mp_h = 0; mp_l = 0; me_h = 0; me_l = 0; mdead = 0; mwin = 1; mflt = 0;
        end else begin
            wh = mode_3x ? cmd_hi : (cmd_hi && !cmd_lo);
            wl = mode_3x ? !cmd_hi : (cmd_lo && !cmd_hi);
            bh = (mp_h == 3 && wh && me_h >= mwin && !vgs_hi_mon) || (mp_h == 5 && me_h >= mwin && vgs_hi_mon);
            bl = (mp_l == 3 && wl && me_l >= mwin && !vgs_lo_mon) || (mp_l == 5 && me_l >= mwin && vgs_lo_mon);
            kill = mflt || bh || bl;
            side_step(mp_h, me_h, wh, mp_l, vgs_lo_mon, kill, nph, neh);
            side_step(mp_l, me_l, wl, mp_h, vgs_hi_mon, kill, npl, nel);
            if ((mp_h == 0 || mp_h == 4) && (mp_l == 0 || mp_l == 4)) begin
                mdead = cfg_dead;
                mwin  = (cfg_win == 0) ? 1 : cfg_win;
            end
            if (bh || bl) mflt = 1; else if (fault_clr) mflt = 0;
            mp_h = nph; me_h = neh; mp_l = npl; me_l = nel;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 gate_hi vs model", gate_hi, (mp_h == 3 || mp_h == 4));
            chk("R1 gate_lo vs model", gate_lo, (mp_l == 3 || mp_l == 4));
            chk("R7 pull_lo vs model", pull_lo, (mp_h == 3 || mp_h == 5));
            chk("R7 pull_hi vs model", pull_hi, (mp_l == 3 || mp_l == 5));
            chk("R8 fault vs model", fault, mflt);
            chk("R6 both gates on", gate_hi && gate_lo, 0);
            chk("R11 both pulldowns on", pull_hi && pull_lo, 0);
        end
    end

    // directed timing monitors: entry gap and window length
    bit    meas_en = 1'b1;
    int    exp_dead = 2, exp_win = 4;
    string dead_tag = "R5";
    int    cnt_h = 0, cnt_l = 0, run_h = 0, run_l = 0;
    bit    gh_p = 0, gl_p = 0;

    always @(negedge clk) begin : timing_mon
        bit wh, wl;
        if (!rst_n) begin
            cnt_h = 0; cnt_l = 0; run_h = 0; run_l = 0; gh_p = 0; gl_p = 0;
        end else begin
            wh = mode_3x ? cmd_hi : (cmd_hi && !cmd_lo);
            wl = mode_3x ? !cmd_hi : (cmd_lo && !cmd_hi);
            if (gate_hi && !gh_p && meas_en) begin
                chk("R4 high entry after low released", cnt_h > 0, 1);
                chk({dead_tag, " high dead time"}, cnt_h, exp_dead + 1);
            end
            if (gate_lo && !gl_p && meas_en) begin
                chk("R4 low entry after high released", cnt_l > 0, 1);
                chk({dead_tag, " low dead time"}, cnt_l, exp_dead + 1);
            end
            cnt_h = (wh && !gate_hi && !gate_lo && !pull_hi && !vgs_lo_mon && !fault) ? cnt_h + 1 : 0;
            cnt_l = (wl && !gate_lo && !gate_hi && !pull_lo && !vgs_hi_mon && !fault) ? cnt_l + 1 : 0;
            if (pull_lo) run_h++;
            else begin
                if (run_h > 0 && meas_en) chk("R7 high window length", run_h, exp_win);
                run_h = 0;
            end
            if (pull_hi) run_l++;
            else begin
                if (run_l > 0 && meas_en) chk("R7 low window length", run_l, exp_win);
                run_l = 0;
            end
            gh_p = gate_hi; gl_p = gate_lo;
        end
    end

    task automatic drive(input logic m, input logic h, input logic l);
        @(negedge clk); #1;
        mode_3x = m; cmd_hi = h; cmd_lo = l;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); #1 fault_clr = 1'b1;
        @(negedge clk);
        chk("R9 fault cleared by pulse", fault, 0);
        #1 fault_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        settle(3);
        chk("R6 reset gate_hi", gate_hi, 0);
        chk("R6 reset gate_lo", gate_lo, 0);
        chk("R9 reset fault", fault, 0);
        #1 rst_n = 1'b1;

        // six-input basic
        drive(0, 1, 0); settle(30);
        chk("R1 high follows cmd_hi", gate_hi, 1);
        drive(0, 0, 1); settle(30);
        chk("R1 low follows cmd_lo", gate_lo, 1);
        chk("R1 high released", gate_hi, 0);

        // both commands high
        drive(0, 1, 1); settle(30);
        chk("R2 both high: gate_hi off", gate_hi, 0);
        chk("R2 both high: gate_lo off", gate_lo, 0);
        drive(0, 1, 0); settle(30);
        chk("R2 recover to high", gate_hi, 1);

        // zero dead time
        cfg_dead = 4'd0; exp_dead = 0;
        drive(0, 0, 1); settle(30);
        chk("R5 zero dead, low on", gate_lo, 1);

        // configuration changed mid-transition: old value applies
        cfg_dead = 4'd2; settle(2); exp_dead = 2;
        drive(0, 1, 0); dead_tag = "R10";
        settle(2); cfg_dead = 4'd5;
        settle(30);
        chk("R10 high on after mid change", gate_hi, 1);
        exp_dead = 5;
        drive(0, 0, 1); settle(40);
        chk("R10 new dead time applied, low on", gate_lo, 1);
        dead_tag = "R5";

        // turn-off fault: high monitor stuck at 1 when releasing high
        drive(0, 1, 0); settle(40);
        meas_en = 0;
        stuck_h_en = 1; stuck_h_val = 1;
        drive(0, 0, 1); settle(30);
        chk("R8 turn-off fault raised", fault, 1);
        chk("R9 fault holds gate_lo off", gate_lo, 0);
        drive(0, 1, 0); settle(20);
        chk("R9 commands ignored while faulted", gate_hi, 0);
        chk("R9 fault sticky", fault, 1);
        stuck_h_en = 0; settle(2);
        pulse_clr(); settle(40);
        chk("R9 resumes after clear", gate_hi, 1);

        // turn-on fault: high monitor stuck at 0
        drive(0, 0, 1); settle(40);
        stuck_h_en = 1; stuck_h_val = 0;
        drive(0, 1, 0); settle(40);
        chk("R8 turn-on fault raised", fault, 1);
        chk("R9 fault holds gate_hi off", gate_hi, 0);
        stuck_h_en = 0; settle(2);
        pulse_clr(); settle(40);
        meas_en = 1;
        chk("R9 high on after second clear", gate_hi, 1);

        // three-input mode
        drive(1, 1, 0); settle(40);
        chk("R3 cmd_hi=1 selects high", gate_hi, 1);
        for (int i = 0; i < 4; i++) begin
            drive(1, 1, ~cmd_lo); settle(5);
            chk("R3 cmd_lo ignored, high stays", gate_hi, 1);
            chk("R3 cmd_lo ignored, low stays off", gate_lo, 0);
        end
        drive(1, 0, 0); settle(40);
        chk("R3 cmd_hi=0 selects low", gate_lo, 1);
        for (int i = 0; i < 4; i++) begin
            drive(1, 0, ~cmd_lo); settle(5);
            chk("R3 cmd_lo ignored, low stays", gate_lo, 1);
        end

        // scattered commands, model comparison only
        meas_en = 0;
        for (int i = 0; i < 400; i++) begin
            drive(($urandom_range(0, 7) == 0) ? ~mode_3x : mode_3x,
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            settle($urandom_range(0, 12));
        end
        drive(0, 0, 0); settle(40);
        chk("R1 idle after scatter", gate_hi | gate_lo, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule